// File: doc/BRIEF.md
# Selectable Clock Output Generator

This block drives one clock-output pin from one of two sources. In infrared mode the pin carries the serial port's 16x baud clock, so an external infrared encoder/decoder can be clocked in step with the serial data. In divider mode the pin carries the system clock divided by an even ratio of 2, 4, 6 or 8, picked by a two-bit field. An output-enable bit gates the whole pin. The infrared-mode bit only matters while that enable is set.

The 16x baud input is a level square wave from the serial port's baud generator, synchronous to the system clock. It is retimed through one register before it reaches the pin. The divided clock has equal high and low halves at every ratio. Changes to the enable, the mode or the ratio are held back until the pin is low, and also until the retimed baud level is low when switching onto the baud source. This way no shortened high pulse ever reaches the pin. All controls are plain level inputs. There is no streaming interface, so no valid/ready handshake applies.

Top module: `clkout_gen`

## Requirements
- R1: While reset is asserted, and after reset with the enable bit at 0, `clk_out` is 0.
- R2: With `out_en` = 0, `clk_out` stays 0 whatever `ir_mode`, `div_sel` and `baud_x16` do. Setting `ir_mode` alone has no effect.
- R3: With `out_en` = 1 and `ir_mode` = 0, `clk_out` has a period in system clocks set by `div_sel`: 2'b00 gives 2, 2'b01 gives 4, 2'b10 gives 6 and 2'b11 gives 8.
- R4: In divider mode, each high run and each low run of `clk_out` lasts exactly half the selected ratio.
- R5: With `out_en` = 1 and `ir_mode` = 1, `clk_out` equals the value `baud_x16` had one system clock earlier.
- R6: A change of `div_sel`, `ir_mode` or `out_en` that arrives while `clk_out` is 1 leaves the high run in progress at its old length. The new setting is taken up at the first clock edge at which `clk_out` is low.
- R7: When divider mode is enabled from the disabled state, the divider restarts from zero. If the enable is first sampled at clock edge 1, the first rising transition of `clk_out` appears after edge 1 + ratio/2.
- R8: A switch onto the baud source waits until both `clk_out` and the retimed baud level are 0, so a baud high phase already under way is not passed to the pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_x16 | input | 1 | 16x baud square wave, synchronous to `clk` |
| out_en | input | 1 | Clock-output enable |
| ir_mode | input | 1 | Selects the baud source when the output is enabled |
| div_sel | input | 2 | Divide ratio code (00:2, 01:4, 10:6, 11:8) |
| clk_out | output | 1 | Clock-output pin signal |

## Verification
The bench drives every input on the falling clock edge and samples `clk_out` on the falling edge that follows the rising edge where the result is due. In baud mode, that result is the baud level from one sample earlier. When the divider is enabled from the disabled state, the first high sample is due at falling edge ratio/2 + 1 after the enable is driven, because one edge goes to taking up the configuration and ratio/2 edges go to counting. Period and duty checks do not depend on the exact edge at which a change is taken up. They measure whole high and low runs only after a rising transition has been seen, and a run that spans a ratio change is measured against the old half-period.

// File: rtl/clkout_pkg.sv
package clkout_pkg;

  // Width of the ratio selection code
  localparam int SEL_W    = 2;
  // Largest half period in system clocks (ratio 2*2**SEL_W)
  localparam int MAX_HALF = 2 ** SEL_W;
  // Width holding any half period value
  localparam int HALF_W   = $clog2(MAX_HALF + 1);

  typedef enum logic [1:0] {
    SRC_OFF  = 2'd0,
    SRC_BAUD = 2'd1,
    SRC_DIV  = 2'd2
  } src_e;

  typedef struct packed {
    src_e              src;
    logic [HALF_W-1:0] half;
  } cfg_t;

  // Half period for a selection code: code 0 -> 1, code 3 -> 4
  function automatic logic [HALF_W-1:0] half_of(input logic [SEL_W-1:0] sel);
    return HALF_W'(sel) + HALF_W'(1);
  endfunction

endpackage

// File: rtl/clkout_req_decode.sv
module clkout_req_decode
  import clkout_pkg::*;
(
  input  logic             out_en,
  input  logic             ir_mode,
  input  logic [SEL_W-1:0] div_sel,
  output cfg_t             req_cfg
);

  always_comb begin
    req_cfg.half = half_of(div_sel);
    if (!out_en) begin
      req_cfg.src = SRC_OFF;
    end else if (ir_mode) begin
      req_cfg.src = SRC_BAUD;
    end else begin
      req_cfg.src = SRC_DIV;
    end
  end

endmodule

// File: rtl/clkout_baud_retime.sv
module clkout_baud_retime #(
  parameter int STAGES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic baud_in,
  output logic baud_q
);

  logic [STAGES-1:0] pipe;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[0] <= 1'b0;
          else        pipe[0] <= baud_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[g] <= 1'b0;
          else        pipe[g] <= pipe[g-1];
        end
      end
    end
  endgenerate

  assign baud_q = pipe[STAGES-1];

endmodule

// File: rtl/clkout_cfg_hold.sv
module clkout_cfg_hold
  import clkout_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  cfg_t req_cfg,
  input  logic pin_level,
  input  logic baud_level,
  output cfg_t act_cfg,
  output logic commit
);

  logic differs;
  logic safe;

  always_comb begin
    differs = (req_cfg.src != act_cfg.src) ||
              ((req_cfg.src == SRC_DIV) && (req_cfg.half != act_cfg.half));
    // The pin must be low; a switch onto the baud source also needs a low baud level
    safe    = !pin_level && !((req_cfg.src == SRC_BAUD) && baud_level);
    commit  = differs && safe;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_cfg.src  <= SRC_OFF;
      act_cfg.half <= HALF_W'(1);
    end else if (commit) begin
      act_cfg <= req_cfg;
    end
  end

endmodule

// File: rtl/clkout_divider.sv
module clkout_divider
  import clkout_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              restart,
  input  logic [HALF_W-1:0] half,
  output logic [HALF_W-1:0] cnt,
  output logic              phase
);

  logic last;

  assign last = (cnt == half - HALF_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (!run || restart) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (last) begin
      cnt   <= '0;
      phase <= ~phase;
    end else begin
      cnt   <= cnt + HALF_W'(1);
    end
  end

endmodule

// File: rtl/clkout_gen.sv
module clkout_gen
  import clkout_pkg::*;
#(
  parameter int BAUD_STAGES = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             baud_x16,
  input  logic             out_en,
  input  logic             ir_mode,
  input  logic [SEL_W-1:0] div_sel,
  output logic             clk_out
);

  cfg_t              req_cfg;
  cfg_t              act_cfg;
  logic              commit;
  logic              baud_q;
  logic [HALF_W-1:0] div_cnt;
  logic              div_phase;
  src_e              act_src;
  logic [HALF_W-1:0] act_half;

  clkout_req_decode u_req (
    .out_en  (out_en),
    .ir_mode (ir_mode),
    .div_sel (div_sel),
    .req_cfg (req_cfg)
  );

  clkout_baud_retime #(.STAGES(BAUD_STAGES)) u_baud (
    .clk     (clk),
    .rst_n   (rst_n),
    .baud_in (baud_x16),
    .baud_q  (baud_q)
  );

  clkout_cfg_hold u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_cfg    (req_cfg),
    .pin_level  (clk_out),
    .baud_level (baud_q),
    .act_cfg    (act_cfg),
    .commit     (commit)
  );

  assign act_src  = act_cfg.src;
  assign act_half = act_cfg.half;

  clkout_divider u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (act_src == SRC_DIV),
    .restart (commit),
    .half    (act_half),
    .cnt     (div_cnt),
    .phase   (div_phase)
  );

  always_comb begin
    unique case (act_src)
      SRC_BAUD: clk_out = baud_q;
      SRC_DIV:  clk_out = div_phase;
      default:  clk_out = 1'b0;
    endcase
  end

endmodule

// File: rtl/clkout_gen_chk.sv
module clkout_gen_chk
  import clkout_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              baud_x16,
  input logic              out_en,
  input logic              clk_out,
  input src_e              act_src,
  input logic [HALF_W-1:0] act_half,
  input logic [HALF_W-1:0] div_cnt
);

  // R2
  off_holds_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(out_en) && !$past(clk_out)) |-> !clk_out);

  // R6
  cfg_change_when_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((act_src != $past(act_src)) || (act_half != $past(act_half))) |-> !$past(clk_out));

  // R4
  div_cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_src == SRC_DIV) |-> (div_cnt < act_half));

  // R5
  baud_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((act_src == SRC_BAUD) && ($past(act_src) == SRC_BAUD)) |-> (clk_out == $past(baud_x16)));

  // R7
  div_cnt_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((act_src == SRC_OFF) && ($past(act_src) == SRC_OFF)) |-> (div_cnt == '0));

  // R8
  baud_entry_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((act_src == SRC_BAUD) && ($past(act_src) != SRC_BAUD)) |-> !clk_out);

endmodule

bind clkout_gen clkout_gen_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .baud_x16 (baud_x16),
  .out_en   (out_en),
  .clk_out  (clk_out),
  .act_src  (act_src),
  .act_half (act_half),
  .div_cnt  (div_cnt)
);

// File: tb/clkout_gen_tb.sv
module clkout_gen_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_x16 = 1'b0;
  logic       out_en = 1'b0;
  logic       ir_mode = 1'b0;
  logic [1:0] div_sel = 2'b00;
  logic       clk_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  clkout_gen u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .baud_x16 (baud_x16),
    .out_en   (out_en),
    .ir_mode  (ir_mode),
    .div_sel  (div_sel),
    .clk_out  (clk_out)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Wait for a rising transition, then return the high and low run lengths
  task automatic measure(output int hi, output int lo);
    int guard = 0;
    logic prev = clk_out;
    hi = 0; lo = 0;
    while (!(clk_out && !prev) && guard < 100) begin
      prev = clk_out;
      @(negedge clk);
      guard++;
    end
    while (clk_out && hi < 100) begin hi++; @(negedge clk); end
    while (!clk_out && lo < 100) begin lo++; @(negedge clk); end
  endtask

  task automatic go_idle();
    @(negedge clk);
    out_en = 1'b0; ir_mode = 1'b0; baud_x16 = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 low in reset", clk_out, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 low after reset", clk_out, 0);
  endtask

  task automatic t_off_ignores();
    int highs = 0;
    @(negedge clk);
    out_en = 1'b0; ir_mode = 1'b1;
    for (int i = 0; i < 40; i++) begin
      baud_x16 = (i % 4) < 2;
      div_sel = 2'(i % 4);
      @(negedge clk);
      if (clk_out) highs++;
    end
    check("R2 ir_mode alone, output stays low", highs, 0);
    ir_mode = 1'b0; baud_x16 = 1'b0;
  endtask

  task automatic t_ratio(input logic [1:0] sel);
    int hi, lo, half;
    half = int'(sel) + 1;
    @(negedge clk);
    out_en = 1'b1; ir_mode = 1'b0; div_sel = sel;
    measure(hi, lo);
    measure(hi, lo);
    check("R3 period", hi + lo, 2 * half);
    check("R4 high run", hi, half);
    check("R4 low run", lo, half);
  endtask

  task automatic t_first_edge(input logic [1:0] sel);
    int n = 0;
    go_idle();
    div_sel = sel; out_en = 1'b1;
    while (!clk_out && n < 50) begin
      @(negedge clk);
      n++;
    end
    check("R7 first rise after enable", n, int'(sel) + 2);
  endtask

  task automatic t_change_while_high();
    int hi, lo, guard;
    logic prev;
    go_idle();
    div_sel = 2'b11; out_en = 1'b1;
    guard = 0; prev = 1'b0;
    @(negedge clk);
    while (!(clk_out && !prev) && guard < 100) begin
      prev = clk_out;
      @(negedge clk);
      guard++;
    end
    div_sel = 2'b01;
    hi = 0;
    while (clk_out && hi < 100) begin hi++; @(negedge clk); end
    check("R6 high run keeps old length", hi, 4);
    measure(hi, lo);
    measure(hi, lo);
    check("R6 new ratio high run", hi, 2);
    check("R6 new ratio low run", lo, 2);
    // Disable while high: the high run still completes
    guard = 0; prev = 1'b1;
    while (!(clk_out && !prev) && guard < 100) begin
      prev = clk_out;
      @(negedge clk);
      guard++;
    end
    out_en = 1'b0;
    hi = 0;
    while (clk_out && hi < 100) begin hi++; @(negedge clk); end
    check("R6 high run completes on disable", hi, 2);
    lo = 0;
    repeat (10) begin if (clk_out) lo++; @(negedge clk); end
    check("R2 stays low after disable", lo, 0);
  endtask

  task automatic t_baud_follow();
    int bad = 0;
    logic last_b;
    go_idle();
    out_en = 1'b1; ir_mode = 1'b1;
    repeat (4) @(negedge clk);
    last_b = baud_x16;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (clk_out != last_b) bad++;
      baud_x16 = ((i / 5) % 2) == 0;
      last_b = baud_x16;
    end
    check("R5 mismatches against one-clock-delayed baud", bad, 0);
  endtask

  task automatic t_baud_entry();
    int highs = 0;
    go_idle();
    baud_x16 = 1'b1;
    repeat (2) @(negedge clk);
    out_en = 1'b1; ir_mode = 1'b1;
    repeat (5) begin @(negedge clk); if (clk_out) highs++; end
    check("R8 no pulse while baud already high", highs, 0);
    baud_x16 = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 low before fresh baud high", clk_out, 0);
    baud_x16 = 1'b1;
    @(negedge clk);
    check("R8 fresh baud high reaches pin", clk_out, 1);
  endtask

  initial begin
    t_reset();
    t_off_ignores();
    t_ratio(2'b00);
    t_ratio(2'b01);
    t_ratio(2'b10);
    t_ratio(2'b11);
    t_first_edge(2'b00);
    t_first_edge(2'b10);
    t_change_while_high();
    t_baud_follow();
    t_baud_entry();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule